// File: doc/BRIEF.md
# Pipelined sign-magnitude multiplier

This unit is the multiply engine of a 64-bit execution stage. Each cycle it may accept two unsigned operand magnitudes, a flag asking for the product to be negated, and a valid strobe. A fixed number of cycles later it returns the full 128-bit product with its own valid strobe. The product is in two's complement and is negated when the flag was set.

The caller does all the operand shaping. For signed work it passes absolute values and the XOR of the operand signs as the negate flag. For 32-bit work it zero-extends the operands. It then picks the part of the 128-bit result that the instruction needs: bits 63..0 for a low 64-bit multiply, bits 127..64 for a high 64-bit multiply, and bits 63..32 for the high word of a 32-bit multiply. The number of pipeline stages is a parameter. The first stage registers the operands. The second forms the unsigned product. Any further stages only delay it. The last stage applies the negation.

Top module: `smag_mul`

## Requirements
- R1: The stage count DEPTH (default 4, minimum 3) sets the latency. `res_valid` rises exactly DEPTH rising edges after the edge that samples `op_valid` high, and stays low in the cycles in between.
- R2: Each accepted input gives a single one-cycle `res_valid` pulse. Inputs may be accepted on every cycle, and their results leave in the same order, one per cycle.
- R3: With `negate` low, `res_prod` equals the unsigned 128-bit product of `mag_a` and `mag_b`. The test operands 0x1000 and 0x1111 give 0x1111000 with all higher bits zero.
- R4: With `negate` high, `res_prod` equals the two's-complement negation, modulo 2^128, of the full unsigned product. A zero product stays zero.
- R5: The negate flag travels with its own operands. When the flag alternates on back-to-back inputs, each result is negated or not according to its own input.
- R6: `rst` is synchronous. It removes every operation in flight, so `res_valid` is low from the first edge with `rst` high until new inputs have had DEPTH edges to come through. Inputs presented while `rst` is high are dropped.
- R7: Signed 64-bit multiplies work when the caller passes absolute values and the sign XOR as `negate`. Bits 63..0 then hold the low half and bits 127..64 the high half of the signed 128-bit product. This includes operands equal to -2^63, whose magnitude is 0x8000000000000000.
- R8: Signed 32-bit multiplies work when the caller passes zero-extended 32-bit magnitudes. The full result equals the sign-extended signed product, so bits 63..32 hold its high word. This includes operands equal to -2^31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears valid bits only |
| op_valid | input | 1 | Operands on this cycle are to be multiplied |
| mag_a | input | 64 | First operand magnitude, unsigned |
| mag_b | input | 64 | Second operand magnitude, unsigned |
| negate | input | 1 | Negate the product of this operation |
| res_valid | output | 1 | `res_prod` holds a finished product this cycle |
| res_prod | output | 128 | Product in two's complement |

## Verification
The bench builds two copies of the unit from the same stimulus. One uses the default DEPTH of 4. The other uses DEPTH 3, the shallowest allowed, where no delay stage sits between the multiply and the negation. Because the two latencies differ, a result that comes out one cycle early or late on either copy shows up as a mismatch, and back-to-back inputs with alternating negate flags test that the flag moves with its data through both stage layouts. A reset asserted while operations are in flight tests that every stage's valid bit is cleared, not only the last one.

// File: rtl/smag_mul.sv
module smag_mul #(
  parameter int DEPTH = 4,
  parameter int W     = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  input  logic           negate,
  output logic           res_valid,
  output logic [2*W-1:0] res_prod
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(DEPTH + 2) + 1;

  logic [DEPTH:1]  vld_q;
  logic [W-1:0]    a_q, b_q;
  logic            n1_q;
  logic [PW-1:0]   prod_q [2:DEPTH-1];
  logic            neg_q  [2:DEPTH-1];
  logic [PW-1:0]   res_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[DEPTH-1:1], op_valid};
  end

  always_ff @(posedge clk) begin
    a_q       <= mag_a;
    b_q       <= mag_b;
    n1_q      <= negate;
    prod_q[2] <= {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};
    neg_q[2]  <= n1_q;
    for (int k = 3; k < DEPTH; k++) begin
      prod_q[k] <= prod_q[k-1];
      neg_q[k]  <= neg_q[k-1];
    end
    res_q <= neg_q[DEPTH-1] ? -prod_q[DEPTH-1] : prod_q[DEPTH-1];
  end

  assign res_valid = vld_q[DEPTH];
  assign res_prod  = res_q;

  logic [CW-1:0] pend_q;
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_q + CW'(op_valid) - CW'(res_valid);
  end

  a_r2_out_has_owner: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> pend_q != '0);
  a_r1_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    pend_q <= CW'(DEPTH));
  a_r6_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);
  a_r3_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (vld_q[1] && (a_q == '0 || b_q == '0)) |=> prod_q[2] == '0);
  a_r4_negated_sign: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(neg_q[DEPTH-1]) && $past(prod_q[DEPTH-1]) != '0
     && !$past(prod_q[DEPTH-1][PW-1])) |-> res_prod[PW-1]);

  initial begin
    a_r1_min_depth: assert (DEPTH >= 3);
  end
endmodule

// File: tb/test_smag_mul.sv
`timescale 1ns/1ps
module test_smag_mul;
  localparam int DA = 4;
  localparam int DB = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1, op_valid = 1'b0, negate = 1'b0;
  logic [63:0]  mag_a = '0, mag_b = '0;
  logic         ov_a, ov_b;
  logic [127:0] pr_a, pr_b;

  smag_mul i_smag_mul (.clk(clk), .rst(rst), .op_valid(op_valid), .mag_a(mag_a),
    .mag_b(mag_b), .negate(negate), .res_valid(ov_a), .res_prod(pr_a));
  smag_mul #(.DEPTH(DB)) i_smag_mul_d3 (.clk(clk), .rst(rst), .op_valid(op_valid),
    .mag_a(mag_a), .mag_b(mag_b), .negate(negate), .res_valid(ov_b), .res_prod(pr_b));

  int compared = 0, mismatched = 0, edges = 0;
  bit finished = 0;
  always @(posedge clk) edges <= edges + 1;

  logic         sv [2][64];
  logic [127:0] sd [2][64];
  string        st [2][64];

  task automatic check_one(input int u, input logic v, input logic [127:0] d);
    int s = edges % 64;
    compared++;
    if (v !== sv[u][s]) begin
      mismatched++;
      $display("FAIL R1/R2 unit%0d valid act=%b exp=%b at edge %0d", u, v, sv[u][s], edges);
    end else if (sv[u][s]) begin
      compared++;
      if (d !== sd[u][s]) begin
        mismatched++;
        $display("FAIL %s unit%0d act=%h exp=%h", st[u][s], u, d, sd[u][s]);
      end
    end
    sv[u][s] = 1'b0;
  endtask

  task automatic step(input logic r, input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic n, input logic [127:0] e, input string tag);
    @(negedge clk);
    if (finished) return;
    check_one(0, ov_a, pr_a);
    check_one(1, ov_b, pr_b);
    rst = r; op_valid = v; mag_a = a; mag_b = b; negate = n;
    if (r) begin
      for (int u = 0; u < 2; u++) for (int s = 0; s < 64; s++) sv[u][s] = 1'b0;
    end else if (v) begin
      sv[0][(edges + DA) % 64] = 1'b1; sd[0][(edges + DA) % 64] = e; st[0][(edges + DA) % 64] = tag;
      sv[1][(edges + DB) % 64] = 1'b1; sd[1][(edges + DB) % 64] = e; st[1][(edges + DB) % 64] = tag;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, $urandom, $urandom, $urandom, '0, "R1");
  endtask

  task automatic feed_u(input logic [63:0] a, input logic [63:0] b, input logic n, input string tag);
    logic [127:0] p = {64'd0, a} * {64'd0, b};
    step(1'b0, 1'b1, a, b, n, n ? -p : p, tag);
  endtask

  task automatic feed_s64(input logic [63:0] ra, input logic [63:0] rb, input string tag);
    logic [127:0] p = {{64{ra[63]}}, ra} * {{64{rb[63]}}, rb};
    logic [63:0] ma = ra[63] ? -ra : ra;
    logic [63:0] mb = rb[63] ? -rb : rb;
    step(1'b0, 1'b1, ma, mb, ra[63] ^ rb[63], p, tag);
  endtask

  task automatic feed_s32(input logic [31:0] ra, input logic [31:0] rb, input string tag);
    logic [127:0] p = {{96{ra[31]}}, ra} * {{96{rb[31]}}, rb};
    logic [31:0] ma = ra[31] ? -ra : ra;
    logic [31:0] mb = rb[31] ? -rb : rb;
    step(1'b0, 1'b1, {32'd0, ma}, {32'd0, mb}, ra[31] ^ rb[31], p, tag);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    for (int u = 0; u < 2; u++) for (int s = 0; s < 64; s++) sv[u][s] = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, r64(), r64(), 1'b0, '0, "R6");
    idle(2);
    feed_u(64'h1000, 64'h1111, 1'b0, "R3");
    idle(7);
    for (int i = 0; i < 24; i++) feed_u(r64(), r64(), i[0], "R2/R5");
    idle(6);
    for (int i = 0; i < 30; i++) feed_u(r64(), r64(), 1'b1, "R4");
    feed_u(64'd0, r64(), 1'b1, "R4 zero");
    feed_u(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R4 max");
    feed_u(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R3 max");
    idle(5);
    feed_s64(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R7 min*min");
    feed_s64(64'h8000_0000_0000_0000, 64'd1, "R7 min*1");
    feed_s64(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R7 min*-1");
    feed_s64(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R7 max*min");
    for (int i = 0; i < 300; i++) begin
      feed_s64(r64(), r64(), "R7");
      if ($urandom % 4 == 0) idle(1 + $urandom % 5);
    end
    idle(5);
    feed_s32(32'h8000_0000, 32'h8000_0000, "R8 min*min");
    feed_s32(32'h8000_0000, 32'hFFFF_FFFF, "R8 min*-1");
    feed_s32(32'h8000_0000, 32'h7FFF_FFFF, "R8 min*max");
    for (int i = 0; i < 300; i++) begin
      feed_s32($urandom, $urandom, "R8");
      if ($urandom % 4 == 0) idle(1 + $urandom % 5);
    end
    for (int i = 0; i < 3; i++) feed_u(r64(), r64(), 1'b1, "R6 flushed");
    step(1'b1, 1'b1, r64(), r64(), 1'b0, '0, "R6");
    step(1'b1, 1'b0, r64(), r64(), 1'b0, '0, "R6");
    idle(8);
    feed_s64(r64(), r64(), "R6 after");
    idle(8);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule